// File: doc/BRIEF.md
# Synchronous Burst Memory Access Controller

This block sits behind a flow-through synchronous burst memory port and turns its control pins into array accesses. On every rising clock edge it classifies the cycle from its inputs. The cycle kinds are: a new access started by one of two address strobes; a burst step to the next address; a burst pause on the current address; a deselect; or an idle cycle. It then performs the write or read that the cycle calls for on a 36-bit internal array. The array is organised as four 9-bit byte lanes, and each lane can be masked on its own.

Two strobes compete for the port. The processor-side strobe takes priority and always opens with a read. The controller-side strobe may open with a write in the same cycle. A two-bit wraparound counter produces the low address bits of a burst, in linear or interleaved order. Reads are flow-through: the word at the address registered on an edge is presented during the cycle that follows that edge. The data output enable is gated by write detection, by deselects and by an asynchronous output-enable input.

Top module: `sbm_ctrl`

## Requirements
- R1: A strobe loads a new access only when `cen1_n`=0, `cen2`=1 and `cen3_n`=0 at that edge. Any other enable combination with a strobe taken is a deselect. A deselect ends the burst: later cycles without a strobe neither read nor write, and `rdata_oe` is 0 until the next valid start.
- R2: A strobe is taken when `pstb_n`=0 with `cen1_n`=0, or when `cstb_n`=0. If both strobes are low and `cen1_n`=0, the processor strobe wins. With `cen1_n`=1, `pstb_n` is ignored, so that cycle continues the burst unless `cstb_n`=0.
- R3: An access opened by the processor strobe is a read in its first cycle, whatever the write inputs are. The array is not written on that edge.
- R4: An access opened by the controller strobe alone writes `wdata` to `addr` on that same edge if a write is indicated, and is a read otherwise.
- R5: A write is indicated when `gwr_n`=0, or when `bwe_n`=0 and at least one bit of `bsel_n` is 0. `gwr_n`=0 writes all four lanes regardless of `bwe_n` and `bsel_n`.
- R6: `bsel_n[i]`=0 (with `bwe_n`=0, `gwr_n`=1) writes lane i, which is bits [9i+8:9i]. Unselected lanes keep their contents, and any combination of lanes is allowed.
- R7: With no strobe taken during a burst, `adv_n`=0 moves to the next burst address and `adv_n`=1 stays on the current one. The write inputs decide whether the cycle reads or writes.
- R8: `burst_ilv`=0 gives the low two address bits as (start + n) mod 4, and `burst_ilv`=1 gives them as start XOR n. Here n counts the advances since the start. The upper address bits stay fixed and the sequence wraps after four steps.
- R9: After an edge that registers a read address, `rdata` carries that word during the following cycle (flow-through), with `rdata_oe`=1 when `oe_n`=0.
- R10: `rdata_oe` is 0 whenever `oe_n`=1 (asynchronously) or the last cycle was a write. After any write it stays 0 until a strobe starts a new read. `rdata` is all zeros whenever `rdata_oe` is 0.
- R11: After reset no burst is active and `rdata_oe`=0. Advance and write inputs without a burst change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen1_n | input | 1 | Chip enable 1, active low; also qualifies the processor strobe |
| cen2 | input | 1 | Chip enable 2, active high |
| cen3_n | input | 1 | Chip enable 3, active low |
| pstb_n | input | 1 | Processor-side address strobe, active low |
| cstb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | 4 | Per-lane byte selects, active low |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | External word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| rdata | output | 36 | Flow-through read data, zero when disabled |
| rdata_oe | output | 1 | Data output enable |

## Verification
Two things can land on one edge: a strobe that opens a new access, and a burst step that the advance and write inputs would otherwise request. The bench provokes this by driving both strobes low together with the global write low. It also drives the processor strobe low with chip enable 1 high while advance is low. In each case it judges which cycle won by reading the addressed word back and by watching the output enable. It also drives the asynchronous output enable between clock edges to show that it overrides the registered read state without any clock.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
   localparam int unsigned BURST_W = 2;

   typedef enum logic [2:0] {
      CYC_IDLE     = 3'd0,
      CYC_DESEL    = 3'd1,
      CYC_START_RD = 3'd2,
      CYC_START_WR = 3'd3,
      CYC_NEXT_RD  = 3'd4,
      CYC_NEXT_WR  = 3'd5,
      CYC_HOLD_RD  = 3'd6,
      CYC_HOLD_WR  = 3'd7
   } cyc_e;

   function automatic logic cyc_is_write(input cyc_e c);
      return (c == CYC_START_WR) || (c == CYC_NEXT_WR) || (c == CYC_HOLD_WR);
   endfunction

   // low burst address bits for step n from the captured start value
   function automatic logic [BURST_W-1:0] burst_lo(input logic [BURST_W-1:0] start,
                                                  input logic [BURST_W-1:0] n,
                                                  input logic ilv);
      return ilv ? (start ^ n) : (start + n);
   endfunction
endpackage

// File: rtl/sbm_cmd_decode.sv
module sbm_cmd_decode
   import sbm_pkg::*;
#(
   parameter int unsigned LANES = 4
) (
   input  logic             cen1_n,
   input  logic             cen2,
   input  logic             cen3_n,
   input  logic             pstb_n,
   input  logic             cstb_n,
   input  logic             adv_n,
   input  logic             gwr_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bsel_n,
   input  logic             burst_act,
   output cyc_e             cyc,
   output logic [LANES-1:0] lane_we
);
   logic             selected;
   logic             proc_win;
   logic             strobe_taken;
   logic             wr_req;
   logic [LANES-1:0] lane_mask;

   assign selected     = !cen1_n && cen2 && !cen3_n;
   assign proc_win     = !pstb_n && !cen1_n;
   assign strobe_taken = proc_win || !cstb_n;

   always_comb begin
      if (!gwr_n) lane_mask = '1;
      else if (!bwe_n) lane_mask = ~bsel_n;
      else lane_mask = '0;
   end

   assign wr_req = |lane_mask;

   always_comb begin
      if (strobe_taken) begin
         if (!selected) cyc = CYC_DESEL;
         else if (proc_win) cyc = CYC_START_RD;
         else cyc = wr_req ? CYC_START_WR : CYC_START_RD;
      end else if (burst_act) begin
         if (adv_n) cyc = wr_req ? CYC_HOLD_WR : CYC_HOLD_RD;
         else cyc = wr_req ? CYC_NEXT_WR : CYC_NEXT_RD;
      end else begin
         cyc = CYC_IDLE;
      end
   end

   assign lane_we = cyc_is_write(cyc) ? lane_mask : '0;
endmodule

// File: rtl/sbm_burst_seq.sv
module sbm_burst_seq
   import sbm_pkg::*;
#(
   parameter int unsigned AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  cyc_e          cyc,
   input  logic          burst_ilv,
   input  logic [AW-1:0] addr,
   output logic          burst_act,
   output logic [AW-1:0] cur_addr,
   output logic [AW-1:0] acc_addr
);
   localparam int unsigned HI_W = AW - BURST_W;

   logic [HI_W-1:0]    base_hi;
   logic [BURST_W-1:0] start_lo;
   logic [BURST_W-1:0] step_q;
   logic [BURST_W-1:0] step_nx;

   assign step_nx  = step_q + 1'b1;
   assign cur_addr = {base_hi, burst_lo(start_lo, step_q, burst_ilv)};

   always_comb begin
      unique case (cyc)
         CYC_START_RD, CYC_START_WR: acc_addr = addr;
         CYC_NEXT_RD,  CYC_NEXT_WR:  acc_addr = {base_hi, burst_lo(start_lo, step_nx, burst_ilv)};
         default:                    acc_addr = cur_addr;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_act <= 1'b0;
         base_hi   <= '0;
         start_lo  <= '0;
         step_q    <= '0;
      end else begin
         unique case (cyc)
            CYC_START_RD, CYC_START_WR: begin
               burst_act <= 1'b1;
               base_hi   <= addr[AW-1:BURST_W];
               start_lo  <= addr[BURST_W-1:0];
               step_q    <= '0;
            end
            CYC_NEXT_RD, CYC_NEXT_WR: step_q <= step_nx;
            CYC_DESEL:                burst_act <= 1'b0;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/sbm_lane_array.sv
module sbm_lane_array #(
   parameter int unsigned AW     = 8,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 9
) (
   input  logic                    clk,
   input  logic [LANES-1:0]        lane_we,
   input  logic [AW-1:0]           waddr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [AW-1:0]           raddr,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[g]) store[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = store[raddr];
   end
endmodule

// File: rtl/sbm_ctrl.sv
module sbm_ctrl
   import sbm_pkg::*;
#(
   parameter int unsigned AW     = 8,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cen1_n,
   input  logic                    cen2,
   input  logic                    cen3_n,
   input  logic                    pstb_n,
   input  logic                    cstb_n,
   input  logic                    adv_n,
   input  logic                    gwr_n,
   input  logic                    bwe_n,
   input  logic [LANES-1:0]        bsel_n,
   input  logic                    burst_ilv,
   input  logic                    oe_n,
   input  logic [AW-1:0]           addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rdata_oe
);
   localparam int unsigned DW = LANES * LANE_W;

   if (AW <= BURST_W) begin : g_bad_aw
      $error("sbm_ctrl: AW must exceed the burst counter width");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("sbm_ctrl: LANES and LANE_W must be nonzero");
   end

   cyc_e             cyc;
   logic [LANES-1:0] lane_we;
   logic             burst_act;
   logic [AW-1:0]    cur_addr;
   logic [AW-1:0]    acc_addr;
   logic [DW-1:0]    arr_q;
   logic             rd_ok;

   sbm_cmd_decode #(.LANES(LANES)) dec_i (
      .cen1_n(cen1_n), .cen2(cen2), .cen3_n(cen3_n),
      .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
      .gwr_n(gwr_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
      .burst_act(burst_act), .cyc(cyc), .lane_we(lane_we)
   );

   sbm_burst_seq #(.AW(AW)) seq_i (
      .clk(clk), .rst_n(rst_n), .cyc(cyc), .burst_ilv(burst_ilv),
      .addr(addr), .burst_act(burst_act), .cur_addr(cur_addr),
      .acc_addr(acc_addr)
   );

   sbm_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) arr_i (
      .clk(clk), .lane_we(lane_we), .waddr(acc_addr), .wdata(wdata),
      .raddr(cur_addr), .rdata(arr_q)
   );

   // read permission: opened by a strobe read, closed by any write or deselect
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_ok <= 1'b0;
      else if (cyc == CYC_START_RD) rd_ok <= 1'b1;
      else if (cyc_is_write(cyc) || cyc == CYC_DESEL) rd_ok <= 1'b0;
   end

   assign rdata_oe = rd_ok && burst_act && !oe_n;
   assign rdata    = rdata_oe ? arr_q : '0;
endmodule

// File: rtl/sbm_ctrl_chk.sv
module sbm_ctrl_chk #(
   parameter int unsigned AW    = 8,
   parameter int unsigned LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cen1_n,
   input logic             cen2,
   input logic             cen3_n,
   input logic             pstb_n,
   input logic             cstb_n,
   input logic             adv_n,
   input logic             gwr_n,
   input logic             bwe_n,
   input logic [LANES-1:0] bsel_n,
   input logic             oe_n,
   input logic             rdata_oe,
   input logic             burst_act,
   input logic [AW-1:0]    cur_addr
);
   logic sel_c, pwin_c, load_c, wr_c;
   assign sel_c  = !cen1_n && cen2 && !cen3_n;
   assign pwin_c = !pstb_n && !cen1_n;
   assign load_c = pwin_c || !cstb_n;
   assign wr_c   = !gwr_n || (!bwe_n && !(&bsel_n));

   assert_desel_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (load_c && !sel_c) |=> !rdata_oe);

   assert_proc_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pwin_c && sel_c) |=> (rdata_oe == !oe_n));

   assert_write_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_c && !pwin_c && (burst_act || !cstb_n)) |=> !rdata_oe);

   assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !rdata_oe);

   assert_hold_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_c && adv_n) |=> $stable(cur_addr));

   assert_step_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_c && !adv_n && burst_act) |=> (cur_addr != $past(cur_addr)));
endmodule

bind sbm_ctrl sbm_ctrl_chk #(.AW(AW), .LANES(LANES)) chk_i (
   .clk(clk), .rst_n(rst_n), .cen1_n(cen1_n), .cen2(cen2), .cen3_n(cen3_n),
   .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n), .gwr_n(gwr_n),
   .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n), .rdata_oe(rdata_oe),
   .burst_act(burst_act), .cur_addr(cur_addr)
);

// File: tb/sbm_ctrl_tb.sv
module sbm_ctrl_tb_top;
   localparam int unsigned AW = 8;
   localparam int unsigned DW = 36;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cen1_n = 1'b0, cen2 = 1'b1, cen3_n = 1'b0;
   logic          pstb_n = 1'b1, cstb_n = 1'b1, adv_n = 1'b1;
   logic          gwr_n = 1'b1, bwe_n = 1'b1;
   logic [3:0]    bsel_n = 4'hF;
   logic          burst_ilv = 1'b0;
   logic          oe_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rdata_oe;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sbm_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cen1_n(cen1_n), .cen2(cen2), .cen3_n(cen3_n),
      .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n), .gwr_n(gwr_n),
      .bwe_n(bwe_n), .bsel_n(bsel_n), .burst_ilv(burst_ilv), .oe_n(oe_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
   );

   function automatic logic [DW-1:0] pat(input logic [7:0] a);
      return {a, 1'b1, ~a, 1'b0, a + 8'h5B, 1'b1, a ^ 8'hA5, 1'b0};
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one clock: drive at the falling edge, sample at the next falling edge
   task automatic step(input logic p, input logic c, input logic a, input logic g,
                       input logic b, input logic [3:0] s, input logic [AW-1:0] ad,
                       input logic [DW-1:0] d);
      pstb_n = p; cstb_n = c; adv_n = a; gwr_n = g; bwe_n = b; bsel_n = s;
      addr = ad; wdata = d;
      @(posedge clk);
      @(negedge clk);
      pstb_n = 1'b1; cstb_n = 1'b1; adv_n = 1'b1; gwr_n = 1'b1; bwe_n = 1'b1;
      bsel_n = 4'hF;
   endtask

   task automatic wr_word(input logic [AW-1:0] ad, input logic [DW-1:0] d);
      step(1, 0, 1, 0, 1, 4'hF, ad, d);
   endtask

   task automatic rd_start(input logic [AW-1:0] ad);
      step(0, 1, 1, 1, 1, 4'hF, ad, '0);
   endtask

   task automatic adv_rd();
      step(1, 1, 0, 1, 1, 4'hF, '0, '0);
   endtask

   task automatic t_reset();
      chk("R11 oe after reset", {35'd0, rdata_oe}, 36'd0);
      chk("R11 rdata after reset", rdata, 36'd0);
      step(1, 1, 0, 0, 1, 4'hF, '0, 36'h123456789);
      chk("R11 idle advance keeps oe low", {35'd0, rdata_oe}, 36'd0);
   endtask

   task automatic t_single();
      wr_word(8'h10, pat(8'h10));
      chk("R10 oe low after write", {35'd0, rdata_oe}, 36'd0);
      rd_start(8'h10);
      chk("R4 written word read back", rdata, pat(8'h10));
      chk("R9 flow-through oe", {35'd0, rdata_oe}, 36'd1);
      step(0, 1, 1, 0, 0, 4'h0, 8'h10, 36'h0);
      chk("R3 proc start ignores write inputs", rdata, pat(8'h10));
      step(1, 0, 1, 1, 0, 4'hF, 8'h10, 36'h0);
      chk("R5 bwe without selects is read", rdata, pat(8'h10));
      step(1, 0, 1, 1, 1, 4'h0, 8'h10, 36'h0);
      chk("R5 selects without bwe is read", rdata, pat(8'h10));
   endtask

   task automatic t_lanes();
      logic [DW-1:0] m;
      m = pat(8'h10) | {9'h0, 9'h1FF, 9'h0, 9'h1FF};
      step(1, 0, 1, 1, 0, 4'b1010, 8'h10, {DW{1'b1}});
      rd_start(8'h10);
      chk("R6 lanes 0 and 2 only", rdata, m);
      wr_word(8'h11, pat(8'h11));
      step(1, 0, 1, 0, 1, 4'hF, 8'h11, 36'h0);
      rd_start(8'h11);
      chk("R5 global write all lanes", rdata, 36'h0);
   endtask

   task automatic t_linear();
      for (int i = 0; i < 4; i++) wr_word(8'h20 + i[7:0], pat(8'h20 + i[7:0]));
      burst_ilv = 1'b0;
      rd_start(8'h22);
      chk("R8 linear first", rdata, pat(8'h22));
      adv_rd(); chk("R8 linear step 1", rdata, pat(8'h23));
      adv_rd(); chk("R8 linear step 2", rdata, pat(8'h20));
      adv_rd(); chk("R8 linear step 3", rdata, pat(8'h21));
      adv_rd(); chk("R8 linear wrap", rdata, pat(8'h22));
      step(1, 1, 1, 1, 1, 4'hF, '0, '0);
      chk("R7 suspend repeats", rdata, pat(8'h22));
   endtask

   task automatic t_interleave();
      burst_ilv = 1'b1;
      rd_start(8'h21);
      chk("R8 ilv first", rdata, pat(8'h21));
      adv_rd(); chk("R8 ilv step 1", rdata, pat(8'h20));
      adv_rd(); chk("R8 ilv step 2", rdata, pat(8'h23));
      adv_rd(); chk("R8 ilv step 3", rdata, pat(8'h22));
      adv_rd(); chk("R8 ilv wrap", rdata, pat(8'h21));
      burst_ilv = 1'b0;
   endtask

   task automatic t_burst_write();
      wr_word(8'h30, pat(8'h30));
      wr_word(8'h31, pat(8'h31));
      step(0, 1, 1, 0, 1, 4'hF, 8'h30, 36'hEEEEEEEEE);
      chk("R3 first cycle not written", rdata, pat(8'h30));
      step(1, 1, 0, 0, 1, 4'hF, '0, 36'h0E1E1E1E1);
      chk("R10 continue write disables", {35'd0, rdata_oe}, 36'd0);
      adv_rd();
      chk("R10 stays off after write", {35'd0, rdata_oe}, 36'd0);
      rd_start(8'h31);
      chk("R7 continue write hit next addr", rdata, 36'h0E1E1E1E1);
      rd_start(8'h30);
      chk("R3 start addr kept", rdata, pat(8'h30));
   endtask

   task automatic t_priority();
      logic [DW-1:0] m;
      m = pat(8'h10) | {9'h0, 9'h1FF, 9'h0, 9'h1FF};
      step(0, 0, 1, 0, 1, 4'hF, 8'h10, 36'h0);
      chk("R2 both strobes read only", rdata, m);
      chk("R2 both strobes oe", {35'd0, rdata_oe}, 36'd1);
      rd_start(8'h20);
      cen1_n = 1'b1;
      step(0, 1, 0, 1, 1, 4'hF, 8'h33, '0);
      chk("R2 pstb ignored with cen1 high", rdata, pat(8'h21));
      step(1, 0, 1, 1, 1, 4'hF, 8'h33, '0);
      chk("R2 cstb with cen1 high deselects", {35'd0, rdata_oe}, 36'd0);
      cen1_n = 1'b0;
   endtask

   task automatic t_select();
      rd_start(8'h20);
      cen2 = 1'b0;
      step(1, 0, 1, 1, 1, 4'hF, 8'h20, '0);
      chk("R1 cen2 low deselects", {35'd0, rdata_oe}, 36'd0);
      cen2 = 1'b1;
      step(1, 1, 0, 0, 1, 4'hF, '0, 36'h0);
      chk("R1 no access after deselect", {35'd0, rdata_oe}, 36'd0);
      rd_start(8'h20);
      chk("R1 word kept after deselect", rdata, pat(8'h20));
      adv_rd();
      chk("R1 next word kept", rdata, pat(8'h21));
      cen3_n = 1'b1;
      step(0, 1, 1, 1, 1, 4'hF, 8'h20, '0);
      chk("R1 cen3 high deselects", {35'd0, rdata_oe}, 36'd0);
      cen3_n = 1'b0;
   endtask

   task automatic t_oe();
      rd_start(8'h22);
      oe_n = 1'b1; #1;
      chk("R10 oe_n high disables", {35'd0, rdata_oe}, 36'd0);
      chk("R10 rdata zero when off", rdata, 36'd0);
      oe_n = 1'b0; #1;
      chk("R9 oe_n low re-enables", rdata, pat(8'h22));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_lanes();
      t_linear();
      t_interleave();
      t_burst_write();
      t_priority();
      t_select();
      t_oe();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=expired expected=done");
      finish_run();
   end
endmodule